// File: doc/BRIEF.md
# Time-of-Year Calendar Counter

This block keeps wall-clock date and time for a chip. A slow oscillator edge strobe (nominally 32.768 kHz, synchronous to the bus clock) drives a programmable prescaler that produces a one-second tick. Each tick advances seconds, minutes, hours, day of month and month. These fields are packed into one 32-bit time word. A separate 32-bit register holds the full year, for example 2024.

Software sets the time by writing the time word and the year word. Each written value is held and crosses into the slow counter on the second slow edge after the write. A write-pending status bit stays set until that load has happened. The prescaler trim register uses the same scheme with its own pending bit. The block reads back through a coherent snapshot: reading the time word also latches the year, so a later year read matches it even if a tick falls between the two reads.

Top module: `calendar_counter`

## Requirements
- R1: After reset the time reads 1 January 00:00:00. The year reads the `RESET_YEAR` parameter (default 1900), the trim reads `TRIM_RESET` (default 32767), and `bus_rdata` is 0.
- R2: The time word packs its fields as follows: month [31:26] (1..12), day of month [25:21], hour [20:16], minute [15:10], second [9:4]. Bits [3:0] read as zero and written values there are dropped. Writes to the control register change nothing.
- R3: A write to the time word or the year word sets control bit 0. The held value is loaded on the second slow edge after the last such write, and bit 0 clears at that same edge.
- R4: A write to the trim register sets control bit 4. The new trim takes effect on the second slow edge after the write, and bit 4 clears at that edge.
- R5: The tick comes once every trim+1 slow edges. A time load restarts the prescaler, so the first tick arrives trim+1 slow edges after the load.
- R6: Seconds and minutes wrap 59 to 0, and hours wrap 23 to 0. The day rolls over after the last day of the month (30 for months 4, 6, 9 and 11, 31 for the others). Month 12 rolls to month 1 and increments the year.
- R7: February has 29 days when the year is divisible by 4, except for 1900. Otherwise it has 28 days. 2000 is a leap year.
- R8: A read of the time word latches the year into a snapshot. Reads of the year word return that snapshot until the next time-word read.
- R9: Control bit 5 (oscillator seen) sets on the first slow edge after reset. Control bit 8 (counter running) sets on the second slow edge.
- R10: The byte offsets are 0x00 control, 0x04 trim, 0x08 time write, 0x0C year write, 0x10 time read and 0x14 year read. Read data appears on the clock edge that samples `bus_re` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_edge | input | 1 | One-cycle strobe per slow oscillator edge |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A read result is due one clock after `bus_re`, so each bench read samples on the following falling edge. A pending bit is due on the edge after the write. It clears on the second slow edge after the write, which is at most two strobe periods plus one clock, so the bench bounds the number of polls it allows. With trim 3 and a strobe every 4 clocks, ticks fall 16, 32 and 48 clocks after a load. The bench reads at about 22 and 40 clocks after the load, which is mid-window and well clear of any tick edge. Each rollover and leap case is loaded one second before the boundary and checked after exactly one tick.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int ADDR_W = 5;
    localparam int WORD_W = 32;

    // status bit positions in the control register
    localparam int ST_WPEND = 0;
    localparam int ST_TPEND = 4;
    localparam int ST_OSC   = 5;
    localparam int ST_RUN   = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 5'h00,
        A_TRIM = 5'h04,
        A_SET0 = 5'h08,
        A_SET1 = 5'h0C,
        A_GET0 = 5'h10,
        A_GET1 = 5'h14
    } reg_addr_e;

    // packed so that {tm, 4'b0} is the time word
    typedef struct packed {
        logic [5:0] month;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic [WORD_W-1:0] year;
        cal_time_t         tm;
    } cal_state_t;

    function automatic logic is_leap(input logic [WORD_W-1:0] y);
        return (y[1:0] == 2'b00) && (y != 32'd1900);
    endfunction

    function automatic logic [4:0] days_in_month(input logic [5:0] m,
                                                 input logic [WORD_W-1:0] y);
        case (m)
            6'd2:                   return is_leap(y) ? 5'd29 : 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11: return 5'd30;
            default:                return 5'd31;
        endcase
    endfunction

    function automatic cal_state_t cal_next(input cal_state_t s);
        cal_state_t n;
        n = s;
        if (s.tm.sec >= 6'd59) begin
            n.tm.sec = '0;
            if (s.tm.min >= 6'd59) begin
                n.tm.min = '0;
                if (s.tm.hour >= 5'd23) begin
                    n.tm.hour = '0;
                    if (s.tm.day >= days_in_month(s.tm.month, s.year)) begin
                        n.tm.day = 5'd1;
                        if (s.tm.month >= 6'd12) begin
                            n.tm.month = 6'd1;
                            n.year     = s.year + 1'b1;
                        end else begin
                            n.tm.month = s.tm.month + 1'b1;
                        end
                    end else begin
                        n.tm.day = s.tm.day + 1'b1;
                    end
                end else begin
                    n.tm.hour = s.tm.hour + 1'b1;
                end
            end else begin
                n.tm.min = s.tm.min + 1'b1;
            end
        end else begin
            n.tm.sec = s.tm.sec + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/cal_xfer.sv
// Holds a pending flag from a bus write until the Nth slow edge, then pulses load.
module cal_xfer #(
    parameter int EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_edge,
    input  logic wr,
    output logic pend,
    output logic load
);
    localparam int CW = $clog2(EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

    logic [CW-1:0] stage;

    assign load = pend && slow_edge && !wr && (stage == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            stage <= '0;
        end else if (wr) begin
            pend  <= 1'b1;
            stage <= '0;
        end else if (pend && slow_edge) begin
            if (stage == LAST) begin
                pend  <= 1'b0;
                stage <= '0;
            end else begin
                stage <= stage + 1'b1;
            end
        end
    end

    // R3 / R4: a write always leaves the flag set
    a_r3_wr_sets_pend: assert property (@(posedge clk) disable iff (rst)
        wr |=> pend);
    // R3 / R4: the load edge clears the flag
    a_r4_load_clears: assert property (@(posedge clk) disable iff (rst)
        load |=> !pend);
    // R3: no load without a slow edge
    a_r3_load_on_edge: assert property (@(posedge clk) disable iff (rst)
        load |-> slow_edge);

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TRIM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_edge,
    input  logic [TRIM_W-1:0] trim,
    input  logic              restart,
    output logic              tick
);
    logic [TRIM_W-1:0] cnt;

    assign tick = slow_edge && !restart && (cnt >= trim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (slow_edge) begin
            if (cnt >= trim) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R5: a restart leaves the count at zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));
    // R5: ticks only on a slow edge
    a_r5_tick_on_edge: assert property (@(posedge clk) disable iff (rst)
        tick |-> slow_edge);

endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_YEAR = 32'd1900
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_tm,
    input  logic              load_yr,
    input  cal_time_t         tm_in,
    input  logic [WORD_W-1:0] yr_in,
    output cal_state_t        state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state.year     <= RESET_YEAR;
            state.tm.month <= 6'd1;
            state.tm.day   <= 5'd1;
            state.tm.hour  <= '0;
            state.tm.min   <= '0;
            state.tm.sec   <= '0;
        end else if (load_tm || load_yr) begin
            if (load_tm) state.tm   <= tm_in;
            if (load_yr) state.year <= yr_in;
        end else if (tick) begin
            state <= cal_next(state);
        end
    end

    // R6: after a tick the clock fields are in range
    a_r6_fields_legal: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_tm && !load_yr) |=>
            (state.tm.sec <= 6'd59 && state.tm.min <= 6'd59 && state.tm.hour <= 5'd23));
    // R6: a tick moves the year by at most one
    a_r6_year_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_yr) |=>
            (state.year == $past(state.year) || state.year == $past(state.year) + 1'b1));
    // R7: a tick never lands on day 29 of a common-year February
    a_r7_feb_common: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_tm && !load_yr) |=>
            !(state.tm.month == 6'd2 && state.tm.day > 5'd28 && !is_leap(state.year)));

endmodule

// File: rtl/calendar_counter.sv
module calendar_counter
    import cal_pkg::*;
#(
    parameter int                TRIM_W     = 16,
    parameter logic [TRIM_W-1:0] TRIM_RESET = 16'd32767,
    parameter logic [31:0]       RESET_YEAR = 32'd1900,
    parameter int                SYNC_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_edge,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int PAD_W = WORD_W - TRIM_W;

    // write decode
    logic we_set0, we_set1, we_trim;
    assign we_set0 = bus_we && (bus_addr == A_SET0);
    assign we_set1 = bus_we && (bus_addr == A_SET1);
    assign we_trim = bus_we && (bus_addr == A_TRIM);

    // held values waiting to cross
    cal_time_t         tm_hold;
    logic [WORD_W-1:0] yr_hold;
    logic              have_tm, have_yr;
    logic [TRIM_W-1:0] trim_hold, trim_q;

    logic set_pend, set_load, trim_pend, trim_load, tick;
    cal_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_hold   <= '0;
            yr_hold   <= '0;
            have_tm   <= 1'b0;
            have_yr   <= 1'b0;
            trim_hold <= TRIM_RESET;
        end else begin
            if (set_load) begin
                have_tm <= 1'b0;
                have_yr <= 1'b0;
            end
            if (we_set0) begin
                tm_hold <= bus_wdata[WORD_W-1:4];
                have_tm <= 1'b1;
            end
            if (we_set1) begin
                yr_hold <= bus_wdata;
                have_yr <= 1'b1;
            end
            if (we_trim) trim_hold <= bus_wdata[TRIM_W-1:0];
        end
    end

    cal_xfer #(.EDGES(SYNC_EDGES)) u_set_xfer (
        .clk(clk), .rst(rst), .slow_edge(slow_edge),
        .wr(we_set0 || we_set1), .pend(set_pend), .load(set_load)
    );

    cal_xfer #(.EDGES(SYNC_EDGES)) u_trim_xfer (
        .clk(clk), .rst(rst), .slow_edge(slow_edge),
        .wr(we_trim), .pend(trim_pend), .load(trim_load)
    );

    always_ff @(posedge clk) begin
        if (rst)            trim_q <= TRIM_RESET;
        else if (trim_load) trim_q <= trim_hold;
    end

    cal_prescaler #(.TRIM_W(TRIM_W)) u_presc (
        .clk(clk), .rst(rst), .slow_edge(slow_edge),
        .trim(trim_q), .restart(set_load), .tick(tick)
    );

    cal_core #(.RESET_YEAR(RESET_YEAR)) u_core (
        .clk(clk), .rst(rst), .tick(tick),
        .load_tm(set_load && have_tm), .load_yr(set_load && have_yr),
        .tm_in(tm_hold), .yr_in(yr_hold), .state(state)
    );

    // oscillator / running status
    logic [1:0] edge_cnt;
    logic       osc_seen, running;
    assign osc_seen = (edge_cnt != 2'd0);
    assign running  = (edge_cnt == 2'd2);

    always_ff @(posedge clk) begin
        if (rst)                         edge_cnt <= '0;
        else if (slow_edge && !running)  edge_cnt <= edge_cnt + 1'b1;
    end

    logic [WORD_W-1:0] status;
    always_comb begin
        status           = '0;
        status[ST_WPEND] = set_pend;
        status[ST_TPEND] = trim_pend;
        status[ST_OSC]   = osc_seen;
        status[ST_RUN]   = running;
    end

    // registered reads with a coherent year snapshot
    logic [WORD_W-1:0] snap_year;
    logic              rd_get0;
    assign rd_get0 = bus_re && (bus_addr == A_GET0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            snap_year <= RESET_YEAR;
        end else if (bus_re) begin
            case (bus_addr)
                A_CTRL:  bus_rdata <= status;
                A_TRIM:  bus_rdata <= {{PAD_W{1'b0}}, trim_q};
                A_GET0: begin
                    bus_rdata <= {state.tm, 4'b0000};
                    snap_year <= state.year;
                end
                A_GET1:  bus_rdata <= snap_year;
                default: bus_rdata <= '0;
            endcase
        end
    end

    // R8: the snapshot only moves on a time-word read
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_get0 |=> $stable(snap_year));
    // R10: read data holds when no read is issued
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));
    // R4: trim only changes through its crossing
    a_r4_trim_stable: assert property (@(posedge clk) disable iff (rst)
        !trim_load |=> $stable(trim_q));
    // R9: running implies the oscillator has been seen
    a_r9_run_osc: assert property (@(posedge clk) disable iff (rst)
        running |-> osc_seen);

endmodule

// File: tb/calendar_counter_tb.sv
module calendar_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_edge = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [4:0] CTRL = 5'h00, TRIM = 5'h04, SET0 = 5'h08,
                           SET1 = 5'h0C, GET0 = 5'h10, GET1 = 5'h14;

    calendar_counter u_dut (
        .clk(clk), .rst(rst), .slow_edge(slow_edge),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;   // 50 MHz

    // slow edge strobe: one clock high in every four
    initial begin
        forever begin
            repeat (3) begin @(negedge clk); slow_edge = 1'b0; end
            @(negedge clk); slow_edge = 1'b1;
        end
    end

    function automatic logic [31:0] w0(int mo, int d, int h, int mi, int s);
        return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) |
               (32'(mi) << 10) | (32'(s) << 4);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    // poll a control bit until clear; load is due within two strobe periods
    task automatic wait_clear(int bitpos, string req);
        logic [31:0] v;
        int polls = 0;
        v = 32'hFFFF_FFFF;
        while (v[bitpos] && polls < 20) begin
            bus_read(CTRL, v);
            polls++;
        end
        chk({req, " pending cleared"}, 32'(v[bitpos]), 32'd0);
        chk({req, " clear within two slow edges"}, 32'(polls <= 6), 32'd1);
    endtask

    task automatic set_time(logic [31:0] t, logic [31:0] y);
        logic [31:0] v;
        bus_write(SET0, t);
        bus_write(SET1, y);
        bus_read(CTRL, v);
        chk("R3 write pending set", 32'(v[0]), 32'd1);
        wait_clear(0, "R3");
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 rdata at reset", bus_rdata, 32'd0);
        bus_read(GET0, v);  chk("R1 reset time", v, w0(1, 1, 0, 0, 0));
        bus_read(GET1, v);  chk("R1 reset year", v, 32'd1900);
        bus_read(TRIM, v);  chk("R1 reset trim", v, 32'd32767);
        repeat (12) @(negedge clk);
        bus_read(CTRL, v);  chk("R9 osc and running bits", v, 32'h120);
    endtask

    task automatic t_ctrl_ignore;
        logic [31:0] v;
        bus_write(CTRL, 32'hFFFF_FFFF);
        repeat (12) @(negedge clk);
        bus_read(CTRL, v);  chk("R2 control write ignored", v, 32'h120);
    endtask

    task automatic t_trim;
        logic [31:0] v;
        bus_write(TRIM, 32'd3);
        bus_read(CTRL, v);  chk("R4 trim pending set", 32'(v[4]), 32'd1);
        wait_clear(4, "R4");
        bus_read(TRIM, v);  chk("R4 R10 trim read back", v, 32'd3);
    endtask

    task automatic t_set_and_tick;
        logic [31:0] v;
        set_time(w0(1, 15, 10, 20, 30) | 32'hF, 32'd2024);
        bus_read(GET0, v);  chk("R2 R3 time loaded, low bits zero", v, w0(1, 15, 10, 20, 30));
        bus_read(GET1, v);  chk("R3 year loaded", v, 32'd2024);
        repeat (16) @(negedge clk);
        bus_read(GET0, v);  chk("R5 one tick after trim+1 edges", v, w0(1, 15, 10, 20, 31));
        repeat (16) @(negedge clk);
        bus_read(GET0, v);  chk("R5 second tick one period later", v, w0(1, 15, 10, 20, 32));
    endtask

    task automatic t_roll(string req, logic [31:0] t0, logic [31:0] y0,
                          logic [31:0] t1, logic [31:0] y1);
        logic [31:0] v;
        set_time(t0, y0);
        repeat (20) @(negedge clk);
        bus_read(GET0, v);  chk({req, " time"}, v, t1);
        bus_read(GET1, v);  chk({req, " year"}, v, y1);
    endtask

    task automatic t_snapshot;
        logic [31:0] v;
        set_time(w0(12, 31, 23, 59, 59), 32'd1999);
        bus_read(GET0, v);  chk("R8 time before tick", v, w0(12, 31, 23, 59, 59));
        repeat (20) @(negedge clk);
        bus_read(GET1, v);  chk("R8 year from snapshot", v, 32'd1999);
        bus_read(GET0, v);  chk("R8 fresh time", v, w0(1, 1, 0, 0, 0));
        bus_read(GET1, v);  chk("R8 fresh year", v, 32'd2000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_ignore();
        t_trim();
        t_set_and_tick();
        t_roll("R6 hour carry", w0(1, 15, 10, 59, 59), 2024, w0(1, 15, 11, 0, 0), 2024);
        t_roll("R6 month end 31", w0(1, 31, 23, 59, 59), 2024, w0(2, 1, 0, 0, 0), 2024);
        t_roll("R6 month end 30", w0(4, 30, 23, 59, 59), 2023, w0(5, 1, 0, 0, 0), 2023);
        t_roll("R6 year carry", w0(12, 31, 23, 59, 59), 2099, w0(1, 1, 0, 0, 0), 2100);
        t_roll("R7 leap 2000", w0(2, 28, 23, 59, 59), 2000, w0(2, 29, 0, 0, 0), 2000);
        t_roll("R7 1900 common", w0(2, 28, 23, 59, 59), 1900, w0(3, 1, 0, 0, 0), 1900);
        t_roll("R7 common 2023", w0(2, 28, 23, 59, 59), 2023, w0(3, 1, 0, 0, 0), 2023);
        t_roll("R7 leap day end", w0(2, 29, 23, 59, 59), 2024, w0(3, 1, 0, 0, 0), 2024);
        t_snapshot();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule